// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block is the interrupt logic of a real-time clock. Seven event sources feed it: one pulse from the alarm comparator and six pulses from periodic timebase taps. Each pulse sets a sticky flag bit of its own. A mask register decides which flags may raise the interrupt, and an enable bit in a command register gates the output as a whole. When a pending flag meets a set mask bit while the enable is on, a global summary flag is set and the interrupt output goes active.

Software sees three byte-wide registers on a simple single-cycle register bus. A read of the status register returns the flags with the summary flag in the top bit, and that read clears all of them, which takes the interrupt output down. A standby input models the supply going away. While it is high the bus is locked out, but event flags and the interrupt output keep working, so an interrupt can still signal to wake the system.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the flags, the global flag, the interrupt output, the mask register and the enable bit are all 0.
- R2: A one-cycle pulse on a source sets its flag at that clock edge, whether or not it is masked. The status bit positions are: bit 0 for `evt_alarm` and bits 1 to 6 for `evt_periodic[0]` to `evt_periodic[5]`.
- R3: The global flag (status bit 7) is set on the clock edge after a flag is pending whose mask bit is 1 while the enable bit is 1. It is never set otherwise, and it stays set until a status read.
- R4: `irq` is 1 exactly when the global flag is 1 and the enable bit is 1. Clearing the enable bit drops `irq` without clearing the global flag.
- R5: A status read returns the value held before the read. On the edge that completes it, all seven flags and the global flag clear, so `irq` is 0 in the following cycle.
- R6: An event that pulses in the same cycle as a clearing status read is kept. It shows in the next status read and, if masked in, raises the global flag again.
- R7: Mask bits 0 to 6 are read/write. Mask bit 7 reads 0 and ignores writes. The command register holds only the enable at bit 4, and its other bits read 0.
- R8: While `standby` is 1, bus writes are ignored, reads return 0 and do not clear status, while flags, global flag and `irq` keep working.
- R9: Register addresses: 0 is status, 1 is mask, 2 is command, and 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Battery mode: bus locked out, interrupts still live |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_periodic | input | 6 | Periodic timebase event pulses |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (one cycle) |
| bus_rd | input | 1 | Read strobe (one cycle) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle, 0 otherwise |
| irq | output | 1 | Active-high interrupt request |
| global_flag | output | 1 | Global interrupt flag |

## Verification
The hardest case to reach is an event that lands on the exact edge of a clearing status read. The bench holds a periodic pulse in the same cycle as the read strobe. It then checks three things: the read still returns the old value, the new flag survives, and the global flag comes back one cycle later when that source is masked in. The standby lock-out is the other awkward case. The bench raises an interrupt while standby is high, tries a write and a clearing read, and confirms that neither took effect once the bus returns.

// File: rtl/rtc_irq_pkg.sv
// Shared constants and the register address map of the RTC interrupt
// controller. Assumes one status bit per source plus one summary bit.
package rtc_irq_pkg;

    localparam int PERIODIC_N = 6;
    localparam int BYTE_W     = 8;
    localparam int REG_ADDR_W = 2;
    localparam int EN_BIT_POS = 4;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_STATUS = 2'd0,
        RA_MASK   = 2'd1,
        RA_CMD    = 2'd2,
        RA_SPARE  = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/rtc_irq_flags.sv
// Sticky per-source event flags. Each flag sets on its event pulse and
// clears on the status-read edge, unless its event arrives on that same
// edge. Assumes event inputs are synchronous single-cycle pulses.
module rtc_irq_flags #(
    parameter int SRC_N = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] evt,
    input  logic             clr,
    output logic [SRC_N-1:0] flags
);

    for (genvar g = 0; g < SRC_N; g++) begin : g_flag
        // Capture one source; a read-clear loses to a coincident event.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (clr) begin
                flags[g] <= evt[g];
            end else if (evt[g]) begin
                flags[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtc_irq_regs.sv
// Register-bus decode: mask and command storage, status read strobe and
// read-data mux. Assumes single-cycle read and write strobes. All access
// is locked out while standby is high.
module rtc_irq_regs
    import rtc_irq_pkg::*;
#(
    parameter int SRC_N  = 7,
    parameter int DATA_W = BYTE_W,
    parameter int ADDR_W = REG_ADDR_W,
    parameter int EN_BIT = EN_BIT_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] status_val,
    output logic [SRC_N-1:0]  mask,
    output logic              irq_en,
    output logic              status_clr,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int PAD_W = DATA_W - SRC_N;

    logic              acc_ok;
    logic              wr_ok;
    logic              rd_ok;
    logic [DATA_W-1:0] mask_rd;
    logic [DATA_W-1:0] cmd_rd;

    // Qualify bus strobes with select and the standby lock-out.
    always_comb begin
        acc_ok = bus_sel && !standby;
        wr_ok  = acc_ok && bus_wr;
        rd_ok  = acc_ok && bus_rd;
    end

    // Status read strobe that clears the flags at this edge.
    always_comb begin
        status_clr = rd_ok && (bus_addr == RA_STATUS);
    end

    // Mask register, only the source bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (wr_ok && (bus_addr == RA_MASK)) begin
            mask <= bus_wdata[SRC_N-1:0];
        end
    end

    // Command register, only the enable bit is stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
        end else if (wr_ok && (bus_addr == RA_CMD)) begin
            irq_en <= bus_wdata[EN_BIT];
        end
    end

    // Readback images with unused bits forced to zero.
    always_comb begin
        mask_rd = {{PAD_W{1'b0}}, mask};
        cmd_rd  = '0;
        cmd_rd[EN_BIT] = irq_en;
    end

    // Read-data mux, zero outside a valid read cycle.
    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            case (bus_addr)
                RA_STATUS: bus_rdata = status_val;
                RA_MASK:   bus_rdata = mask_rd;
                RA_CMD:    bus_rdata = cmd_rd;
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/rtc_irq_summary.sv
// Global interrupt flag and output gate. The global flag sets one edge
// after a masked-in flag is pending with the enable on. It holds until a
// status read. The output is the global flag gated by the enable.
module rtc_irq_summary #(
    parameter int SRC_N = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] flags,
    input  logic [SRC_N-1:0] mask,
    input  logic             irq_en,
    input  logic             clr,
    output logic             gflag,
    output logic             irq
);

    logic hit;

    // Any pending flag that the mask lets through while enabled.
    always_comb begin
        hit = irq_en && ((flags & mask) != '0);
    end

    // Sticky summary flag; a status read wins over a new hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gflag <= 1'b0;
        end else if (clr) begin
            gflag <= 1'b0;
        end else if (hit) begin
            gflag <= 1'b1;
        end
    end

    // Output gated by the command enable.
    always_comb begin
        irq = gflag && irq_en;
    end

endmodule

// File: rtl/rtc_irq_ctrl.sv
// Top of the RTC interrupt controller. Packs the alarm and periodic
// events into one source vector, latches them, and builds the summary
// flag and output. Assumes the data width is one bit wider than the
// number of sources.
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int PER_N  = PERIODIC_N,
    parameter int DATA_W = BYTE_W,
    parameter int ADDR_W = REG_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              evt_alarm,
    input  logic [PER_N-1:0]  evt_periodic,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              global_flag
);

    localparam int SRC_N = PER_N + 1;

    logic [SRC_N-1:0]  src_evt;
    logic [SRC_N-1:0]  src_flags;
    logic [SRC_N-1:0]  src_mask;
    logic              irq_en;
    logic              status_clr;
    logic [DATA_W-1:0] status_val;

    // Source vector: alarm at bit 0, periodic taps above it.
    always_comb begin
        src_evt    = {evt_periodic, evt_alarm};
        status_val = {global_flag, src_flags};
    end

    rtc_irq_flags #(.SRC_N(SRC_N)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (src_evt),
        .clr   (status_clr),
        .flags (src_flags)
    );

    rtc_irq_regs #(
        .SRC_N  (SRC_N),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .EN_BIT (EN_BIT_POS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (standby),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .status_val (status_val),
        .mask       (src_mask),
        .irq_en     (irq_en),
        .status_clr (status_clr),
        .bus_rdata  (bus_rdata)
    );

    rtc_irq_summary #(.SRC_N(SRC_N)) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .flags  (src_flags),
        .mask   (src_mask),
        .irq_en (irq_en),
        .clr    (status_clr),
        .gflag  (global_flag),
        .irq    (irq)
    );

endmodule

// File: rtl/rtc_irq_chk.sv
// Property checker for the RTC interrupt controller, bound to the top.
// Observes ports and the signals passed between the submodules.
module rtc_irq_chk #(
    parameter int SRC_N  = 7,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby,
    input logic              bus_sel,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              global_flag,
    input logic [SRC_N-1:0]  src_evt,
    input logic [SRC_N-1:0]  src_flags,
    input logic [SRC_N-1:0]  src_mask,
    input logic              irq_en,
    input logic              status_clr
);

    assert_flag_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt != '0) |=> ((src_flags & $past(src_evt)) == $past(src_evt)));

    assert_global_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(global_flag) |-> $past(irq_en && ((src_flags & src_mask) != '0)));

    assert_irq_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && global_flag));

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |=> (!global_flag && !irq));

    assert_mask_top_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_rd && !standby && bus_addr == 2'd1) |-> !bus_rdata[DATA_W-1]);

    assert_standby_no_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (!status_clr && bus_rdata == '0));

endmodule

bind rtc_irq_ctrl rtc_irq_chk #(
    .SRC_N  (SRC_N),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .standby     (standby),
    .bus_sel     (bus_sel),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .irq         (irq),
    .global_flag (global_flag),
    .src_evt     (src_evt),
    .src_flags   (src_flags),
    .src_mask    (src_mask),
    .irq_en      (irq_en),
    .status_clr  (status_clr)
);

// File: tb/sim_rtc_irq_ctrl.sv
// Directed bench for rtc_irq_ctrl. Inputs change at the falling edge.
// Combinational read data is sampled just after it, before the rising
// edge, and registered outputs one time unit after a rising edge.
module sim_rtc_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       evt_alarm = 1'b0;
    logic [5:0] evt_periodic = '0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       global_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rtc_irq_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .standby      (standby),
        .evt_alarm    (evt_alarm),
        .evt_periodic (evt_periodic),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq          (irq),
        .global_flag  (global_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Read; optional event vector applied in the same cycle.
    task automatic bus_read_evt(input logic [1:0] a, input logic [6:0] ev,
                                output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        evt_alarm = ev[0]; evt_periodic = ev[6:1];
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_rd = 1'b0;
        evt_alarm = 1'b0; evt_periodic = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_read_evt(a, 7'h00, d);
    endtask

    task automatic pulse(input logic [6:0] ev);
        @(negedge clk);
        evt_alarm = ev[0]; evt_periodic = ev[6:1];
        @(posedge clk); #1;
        evt_alarm = 1'b0; evt_periodic = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 irq", irq, 0);
        check("R1 global", global_flag, 0);
        bus_read(2'd1, d); check("R1 mask", d, 8'h00);
        bus_read(2'd2, d); check("R1 cmd", d, 8'h00);
        bus_read(2'd0, d); check("R1 status", d, 8'h00);
    endtask

    task automatic t_unmasked_latch();
        logic [7:0] d;
        bus_write(2'd1, 8'h00);
        bus_write(2'd2, 8'h10);
        pulse(7'b0001001);
        tick(2);
        check("R2 irq off when unmasked", irq, 0);
        bus_read(2'd0, d); check("R2 flags latch unmasked", d, 8'h09);
        bus_read(2'd0, d); check("R5 flags cleared", d, 8'h00);
    endtask

    task automatic t_masked_irq();
        logic [7:0] d;
        bus_write(2'd1, 8'h08);
        pulse(7'b0001000);
        check("R3 global not yet", global_flag, 0);
        tick(1);
        check("R3 global set", global_flag, 1);
        check("R4 irq on", irq, 1);
        bus_read(2'd0, d); check("R5 read pre-clear value", d, 8'h88);
        check("R5 irq off after read", irq, 0);
        check("R5 global off after read", global_flag, 0);
        bus_read(2'd0, d); check("R5 status empty", d, 8'h00);
    endtask

    task automatic t_enable_gate();
        logic [7:0] d;
        bus_write(2'd2, 8'h00);
        bus_write(2'd1, 8'h7F);
        pulse(7'b0000001);
        tick(2);
        check("R3 no global with enable off", global_flag, 0);
        check("R4 no irq with enable off", irq, 0);
        bus_write(2'd2, 8'h10);
        tick(1);
        check("R3 global after enable", global_flag, 1);
        check("R4 irq after enable", irq, 1);
        bus_write(2'd2, 8'h00);
        check("R4 irq drops with enable", irq, 0);
        check("R4 global kept", global_flag, 1);
        bus_read(2'd0, d); check("R4 status", d, 8'h81);
    endtask

    task automatic t_coincident();
        logic [7:0] d;
        bus_write(2'd2, 8'h10);
        bus_write(2'd1, 8'h22);
        pulse(7'b0000010);
        tick(1);
        check("R6 irq before read", irq, 1);
        bus_read_evt(2'd0, 7'b0100000, d);
        check("R6 read value", d, 8'h82);
        check("R6 global cleared", global_flag, 0);
        tick(1);
        check("R6 global re-raised", global_flag, 1);
        bus_read(2'd0, d); check("R6 kept event", d, 8'hA0);
    endtask

    task automatic t_reg_bits();
        logic [7:0] d;
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, d); check("R7 mask bit 7 zero", d, 8'h7F);
        bus_write(2'd2, 8'hFF);
        bus_read(2'd2, d); check("R7 cmd only enable", d, 8'h10);
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, d); check("R9 spare reads 0", d, 8'h00);
        bus_read(2'd1, d); check("R9 mask unchanged by spare", d, 8'h7F);
    endtask

    task automatic t_standby();
        logic [7:0] d;
        bus_write(2'd1, 8'h01);
        bus_write(2'd2, 8'h10);
        bus_read(2'd0, d);
        standby = 1'b1;
        bus_write(2'd1, 8'h00);
        pulse(7'b0000001);
        tick(1);
        check("R8 irq in standby", irq, 1);
        bus_read(2'd0, d); check("R8 read zero in standby", d, 8'h00);
        check("R8 no clear in standby", irq, 1);
        @(negedge clk); standby = 1'b0;
        bus_read(2'd1, d); check("R8 write ignored", d, 8'h01);
        bus_read(2'd0, d); check("R8 status kept", d, 8'h81);
        check("R8 irq cleared after wake read", irq, 0);
    endtask

    initial begin
        tick(3);
        @(negedge clk); rst_n = 1'b1;
        tick(1);
        t_reset();
        t_unmasked_latch();
        t_masked_irq();
        t_enable_gate();
        t_coincident();
        t_reg_bits();
        t_standby();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule